// File: doc/BRIEF.md
# Pipelined Bus Burst Sequencer

This block is the address-side engine of a bus manager on a pipelined AHB-style system bus. Software-facing logic inside the manager hands it one command at a time. A command gives a start address, a direction, a transfer size, a wrap request and a beat count. The sequencer turns each command into a run of address phases. For every beat it drives the address, the transfer type, the direction, the size and a burst-kind code. It moves to the next beat only on a cycle where the bus ready input is high.

Beats after the first follow one another by the transfer size in bytes. A wrapping burst folds its addresses back inside an aligned window. A local stall input lets the manager insert idle cycles in the middle of a burst. During those cycles the bus already shows the address and control of the beat that comes next. For writes, the sequencer also captures one data word per beat and presents it one cycle after that beat's address phase. It holds the word through wait states. A new command can be accepted during the last beat of the current burst, so bursts follow one another with no idle gap.

Top module: `burst_seq`

## Requirements
- R1: While the active-low reset is asserted, and immediately on its asynchronous assertion, the transfer type is IDLE (2'b00). Address, direction, size, burst code and write data are all zero. After release, cmd_ready is high whenever bus_ready is high.
- R2: Transfer types are encoded as follows: IDLE=2'b00, BUSY=2'b01, NONSEQ=2'b10, SEQ=2'b11. The cycle after a command is accepted shows its first beat as NONSEQ at the start address. A beat count of 1 or 0 produces one NONSEQ beat followed by IDLE.
- R3: Every later beat is SEQ. Its direction, size and burst code equal those of the first beat. An incrementing burst advances the address by 2^size bytes per beat.
- R4: When the wrap flag is set and the beat count is 4, 8 or 16, addresses stay inside an aligned window of count × 2^size bytes. They wrap to the window base after its top.
- R5: With a beat count other than 4, 8 or 16, the wrap flag is ignored and the burst increments. An incrementing burst crosses any address boundary without wrapping.
- R6: The burst code is fixed by the count and the wrap flag. It is 0 for one beat (or 0). It is 2/3 for four beats (wrapping/incrementing), 4/5 for eight beats and 6/7 for sixteen beats. Any other count gives code 1.
- R7: If stall is high at a clock edge that ends a beat with more beats to follow, the next cycle shows BUSY with the next beat's address and control. BUSY repeats while stall stays high. The beat then appears as SEQ at the same address. A first beat and the cycle after a last beat are never BUSY.
- R8: While bus_ready is low, address, transfer type, direction and size do not change.
- R9: cmd_ready is high only when bus_ready is high and the bus shows IDLE or the last beat of a burst. A command offered during the last beat is taken, and its NONSEQ follows directly.
- R10: For a write beat, wd_pop is high while that beat's address phase ends with bus_ready high. The wdata_in value at that edge appears on bus_wdata in the next cycle and is held while bus_ready is low.
- R11: Read beats keep wd_pop low and leave bus_wdata unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, rising edge active |
| rst_n | input | 1 | Active-low reset, asynchronous assert, synchronous release |
| cmd_valid | input | 1 | A command is offered |
| cmd_ready | output | 1 | The sequencer takes the offered command at this edge |
| cmd_addr | input | ADDR_W | Start address of the burst |
| cmd_write | input | 1 | 1 for write, 0 for read |
| cmd_size | input | 3 | Transfer size, 2^size bytes per beat |
| cmd_wrap | input | 1 | Request a wrapping burst |
| cmd_beats | input | BEAT_W | Beat count (0 treated as 1) |
| stall | input | 1 | Insert BUSY before the next beat of the current burst |
| wdata_in | input | DATA_W | Write data for the beat whose address phase is ending |
| wd_pop | output | 1 | wdata_in is captured at this edge |
| bus_ready | input | 1 | Bus ready; low extends the current phase |
| bus_addr | output | ADDR_W | Bus address |
| bus_trans | output | 2 | Transfer type |
| bus_write | output | 1 | Bus direction |
| bus_size | output | 3 | Bus transfer size |
| bus_burst | output | 3 | Burst kind code |
| bus_wdata | output | DATA_W | Write data of the current data phase |

## Verification
The bench targets wrap windows entered at an offset in the middle of the window, incrementing bursts that cross a power-of-two boundary, and wrap requests with counts that cannot wrap. A design that got these wrong would fold addresses at the wrong base or wrap where it must not. Stall tests cover a stall held over the last beat, where a BUSY without a following beat would be a protocol error, and a stall present at command acceptance, where the first beat must still be NONSEQ. Wait states on a write burst show whether the design lets the address run ahead or lets the write data slip. A command offered in the middle of a burst and kept until the last beat shows whether the design accepts it too early or leaves an idle gap.

// File: rtl/burst_seq.sv
module burst_seq #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int MAX_BEATS = 16,
  localparam int BEAT_W = $clog2(MAX_BEATS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic              cmd_write,
  input  logic [2:0]        cmd_size,
  input  logic              cmd_wrap,
  input  logic [BEAT_W-1:0] cmd_beats,
  input  logic              stall,
  input  logic [DATA_W-1:0] wdata_in,
  output logic              wd_pop,
  input  logic              bus_ready,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [1:0]        bus_trans,
  output logic              bus_write,
  output logic [2:0]        bus_size,
  output logic [2:0]        bus_burst,
  output logic [DATA_W-1:0] bus_wdata
);

  localparam logic [1:0] TR_IDLE = 2'b00;
  localparam logic [1:0] TR_BUSY = 2'b01;
  localparam logic [1:0] TR_NSEQ = 2'b10;
  localparam logic [1:0] TR_SEQ  = 2'b11;

  logic [BEAT_W-1:0] rem, beats_eff;
  logic [ADDR_W-1:0] wmask, new_mask, step_addr, next_addr;
  logic [2:0]        new_burst;
  logic              wrap_ok, beat, last, take;

  assign beat      = bus_trans[1];
  assign last      = beat && (rem == '0);
  assign cmd_ready = bus_ready && ((bus_trans == TR_IDLE) || last);
  assign take      = cmd_valid && cmd_ready;
  assign wd_pop    = bus_ready && beat && bus_write;

  assign beats_eff = (cmd_beats == '0) ? BEAT_W'(1) : cmd_beats;
  assign wrap_ok   = cmd_wrap && (cmd_beats == BEAT_W'(4) || cmd_beats == BEAT_W'(8) ||
                                  cmd_beats == BEAT_W'(16));
  assign new_mask  = wrap_ok ? ((ADDR_W'(cmd_beats) << cmd_size) - ADDR_W'(1)) : '1;
  assign step_addr = bus_addr + (ADDR_W'(1) << bus_size);
  assign next_addr = (bus_addr & ~wmask) | (step_addr & wmask);

  always_comb begin
    new_burst = 3'd1;
    if (beats_eff == BEAT_W'(1))       new_burst = 3'd0;
    else if (cmd_beats == BEAT_W'(4))  new_burst = wrap_ok ? 3'd2 : 3'd3;
    else if (cmd_beats == BEAT_W'(8))  new_burst = wrap_ok ? 3'd4 : 3'd5;
    else if (cmd_beats == BEAT_W'(16)) new_burst = wrap_ok ? 3'd6 : 3'd7;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_trans <= TR_IDLE;
      bus_addr  <= '0;
      bus_write <= 1'b0;
      bus_size  <= 3'd0;
      bus_burst <= 3'd0;
      bus_wdata <= '0;
      rem       <= '0;
      wmask     <= '1;
    end else if (bus_ready) begin
      if (beat && bus_write) bus_wdata <= wdata_in;
      if (take) begin
        bus_trans <= TR_NSEQ;
        bus_addr  <= cmd_addr;
        bus_write <= cmd_write;
        bus_size  <= cmd_size;
        bus_burst <= new_burst;
        wmask     <= new_mask;
        rem       <= beats_eff - BEAT_W'(1);
      end else if (beat && rem != '0) begin
        bus_addr  <= next_addr;
        rem       <= rem - BEAT_W'(1);
        bus_trans <= stall ? TR_BUSY : TR_SEQ;
      end else if (bus_trans == TR_BUSY) begin
        bus_trans <= stall ? TR_BUSY : TR_SEQ;
      end else begin
        bus_trans <= TR_IDLE;
      end
    end
  end

  // R2
  first_nonseq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready) |=> (bus_trans == TR_NSEQ));

  // R3
  seq_has_lead_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_trans == TR_SEQ || bus_trans == TR_BUSY) |-> ($past(bus_trans) != TR_IDLE));

  // R3
  seq_ctrl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_trans == TR_SEQ && $past(bus_ready)) |->
      ($stable(bus_write) && $stable(bus_size) && $stable(bus_burst)));

  // R3
  incr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_trans == TR_SEQ && $past(bus_trans[1]) && $past(bus_ready) && bus_burst[0]) |->
      (bus_addr == $past(bus_addr) + (ADDR_W'(1) << bus_size)));

  // R7
  busy_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(bus_trans) == TR_BUSY && bus_trans == TR_SEQ) |-> $stable(bus_addr));

  // R8
  wait_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_ready |=> ($stable(bus_addr) && $stable(bus_trans) && $stable(bus_write) &&
                    $stable(bus_size)));

  // R10
  wdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_ready |=> $stable(bus_wdata));

endmodule

// File: tb/burst_seq_test.sv
module burst_seq_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0, cmd_ready;
  logic [31:0] cmd_addr = '0;
  logic        cmd_write = 1'b0;
  logic [2:0]  cmd_size = '0;
  logic        cmd_wrap = 1'b0;
  logic [4:0]  cmd_beats = '0;
  logic        stall = 1'b0;
  logic [31:0] wdata_in = '0;
  logic        wd_pop;
  logic        bus_ready = 1'b1;
  logic [31:0] bus_addr;
  logic [1:0]  bus_trans;
  logic        bus_write;
  logic [2:0]  bus_size, bus_burst;
  logic [31:0] bus_wdata;

  int errors = 0, checks = 0;

  burst_seq uut (.clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_addr(cmd_addr), .cmd_write(cmd_write), .cmd_size(cmd_size), .cmd_wrap(cmd_wrap),
    .cmd_beats(cmd_beats), .stall(stall), .wdata_in(wdata_in), .wd_pop(wd_pop),
    .bus_ready(bus_ready), .bus_addr(bus_addr), .bus_trans(bus_trans), .bus_write(bus_write),
    .bus_size(bus_size), .bus_burst(bus_burst), .bus_wdata(bus_wdata));

  always #4 clk = ~clk;

  typedef struct packed {
    logic [31:0] addr; logic wr; logic [2:0] size; logic wrap; logic [4:0] beats; logic [2:0] burst;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VEC [NV] = '{
    '{32'h100, 1'b0, 3'd2, 1'b0, 5'd1,  3'd0},
    '{32'h038, 1'b0, 3'd2, 1'b1, 5'd4,  3'd2},
    '{32'h1F8, 1'b1, 3'd2, 1'b0, 5'd4,  3'd3},
    '{32'h006, 1'b0, 3'd1, 1'b1, 5'd8,  3'd4},
    '{32'h03C, 1'b0, 3'd2, 1'b1, 5'd16, 3'd6},
    '{32'h020, 1'b1, 3'd0, 1'b1, 5'd3,  3'd1},
    '{32'h044, 1'b0, 3'd1, 1'b0, 5'd8,  3'd5},
    '{32'h010, 1'b0, 3'd2, 1'b0, 5'd0,  3'd0},
    '{32'h080, 1'b1, 3'd2, 1'b0, 5'd16, 3'd7}
  };

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic issue(input logic [31:0] a, input logic w, input logic [2:0] s,
                       input logic wr, input logic [4:0] n);
    cmd_addr = a; cmd_write = w; cmd_size = s; cmd_wrap = wr; cmd_beats = n; cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic bus_is(input string req, input logic [1:0] t, input logic [31:0] a);
    chk(req, bus_trans, t);
    chk(req, bus_addr, a);
  endtask

  function automatic logic [31:0] pat(input int v, input int i);
    return 32'hC0DE_0000 | (v << 8) | i;
  endfunction

  function automatic logic [31:0] exp_addr(input vec_t c, input int i);
    int n, sz, total, base, a;
    n = (c.beats == 0) ? 1 : int'(c.beats);
    sz = 1 << c.size;
    a = int'(c.addr);
    if (c.wrap && (n == 4 || n == 8 || n == 16)) begin
      total = n * sz;
      base = (a / total) * total;
      return 32'(base + ((a - base + i * sz) % total));
    end
    return 32'(a + i * sz);
  endfunction

  initial begin
    repeat (20000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] last_wd;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1", bus_trans, 2'b00); chk("R1", bus_addr, 0); chk("R1", bus_write, 0);
    chk("R1", bus_size, 0); chk("R1", bus_burst, 0); chk("R1", bus_wdata, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", cmd_ready, 1);
    last_wd = '0;

    for (int v = 0; v < NV; v++) begin
      vec_t c;
      int n;
      string at;
      c = VEC[v];
      n = (c.beats == 0) ? 1 : int'(c.beats);
      at = (c.wrap && (n == 4 || n == 8 || n == 16)) ? "R4" : ((c.wrap || v == 2) ? "R5" : "R3");
      chk("R9", cmd_ready, 1);
      issue(c.addr, c.wr, c.size, c.wrap, c.beats);
      for (int i = 0; i < n; i++) begin
        chk((i == 0) ? "R2" : "R3", bus_trans, (i == 0) ? 2'b10 : 2'b11);
        chk((i == 0) ? "R2" : at, bus_addr, exp_addr(c, i));
        chk("R3", bus_write, c.wr);
        chk("R3", bus_size, c.size);
        chk("R6", bus_burst, c.burst);
        chk("R9", cmd_ready, (i == n - 1));
        if (c.wr) begin
          chk("R10", wd_pop, 1);
          if (i > 0) chk("R10", bus_wdata, pat(v, i - 1));
        end else begin
          chk("R11", wd_pop, 0);
          chk("R11", bus_wdata, last_wd);
        end
        wdata_in = pat(v, i);
        @(negedge clk);
      end
      chk("R2", bus_trans, 2'b00);
      if (c.wr) begin
        chk("R10", bus_wdata, pat(v, n - 1));
        last_wd = pat(v, n - 1);
      end else chk("R11", bus_wdata, last_wd);
    end

    // R7 stall: first beat NONSEQ, BUSY shows next beat, stall over last beat ignored
    stall = 1'b1;
    issue(32'h200, 1'b0, 3'd2, 1'b0, 5'd4);
    bus_is("R7", 2'b10, 32'h200);
    @(negedge clk); bus_is("R7", 2'b01, 32'h204); chk("R9", cmd_ready, 0);
    @(negedge clk); bus_is("R7", 2'b01, 32'h204);
    stall = 1'b0;
    @(negedge clk); bus_is("R7", 2'b11, 32'h204);
    @(negedge clk); bus_is("R7", 2'b11, 32'h208);
    @(negedge clk); bus_is("R7", 2'b11, 32'h20C);
    stall = 1'b1;
    @(negedge clk); bus_is("R7", 2'b00, 32'h20C);
    stall = 1'b0;

    // R8 and R10: wait states on a write burst
    issue(32'h300, 1'b1, 3'd2, 1'b0, 5'd4);
    bus_is("R2", 2'b10, 32'h300);
    wdata_in = 32'hA0;
    @(negedge clk); bus_is("R3", 2'b11, 32'h304); chk("R10", bus_wdata, 32'hA0);
    bus_ready = 1'b0; wdata_in = 32'hA1;
    #1 chk("R10", wd_pop, 0); chk("R9", cmd_ready, 0);
    @(negedge clk); bus_is("R8", 2'b11, 32'h304); chk("R10", bus_wdata, 32'hA0);
    @(negedge clk); bus_is("R8", 2'b11, 32'h304); chk("R10", bus_wdata, 32'hA0);
    bus_ready = 1'b1;
    @(negedge clk); bus_is("R8", 2'b11, 32'h308); chk("R10", bus_wdata, 32'hA1);
    wdata_in = 32'hA2;
    @(negedge clk); bus_is("R3", 2'b11, 32'h30C); chk("R10", bus_wdata, 32'hA2);
    wdata_in = 32'hA3;
    @(negedge clk); chk("R2", bus_trans, 2'b00); chk("R10", bus_wdata, 32'hA3);

    // R9 back-to-back: command offered mid-burst waits for the last beat
    issue(32'h400, 1'b0, 3'd2, 1'b0, 5'd4);
    bus_is("R9", 2'b10, 32'h400);
    @(negedge clk);
    cmd_addr = 32'h500; cmd_write = 1'b1; cmd_size = 3'd2; cmd_wrap = 1'b0;
    cmd_beats = 5'd1; cmd_valid = 1'b1;
    @(negedge clk); bus_is("R9", 2'b11, 32'h408); chk("R9", bus_write, 0);
    @(negedge clk); bus_is("R9", 2'b11, 32'h40C); chk("R9", cmd_ready, 1);
    @(negedge clk); bus_is("R9", 2'b10, 32'h500); chk("R9", bus_write, 1);
    chk("R6", bus_burst, 3'd0);
    cmd_valid = 1'b0;
    @(negedge clk); chk("R2", bus_trans, 2'b00);

    // R1 asynchronous reset in the middle of a burst
    issue(32'h600, 1'b0, 3'd2, 1'b0, 5'd8);
    @(negedge clk);
    #1 rst_n = 1'b0;
    #1 bus_is("R1", 2'b00, 32'h0); chk("R1", bus_burst, 0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk); chk("R1", bus_trans, 2'b00); chk("R1", cmd_ready, 1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule